// File: doc/BRIEF.md
# Lithium-Ion Charge Phase Sequencer with Over-Charge Timeout

This block is the digital sequencing core of a switch-mode lithium-ion charger. The analog parts of the charger (error amplifiers, sense amplifier, modulator and oscillators) sit outside it. They reach it only as digital flags: the battery is below the trickle threshold, the battery sense is near the target, the charge current has tapered below its programmed minimum, supply undervoltage, and a single-cycle tick from a slow timer prescaler. A host or pushbutton drives a charge request line. The block answers with a two-bit phase code, an enable for the slow timer oscillator, a current/voltage regulation indication, an output-stage enable and a release strobe that pulls the request line low when the over-charge time has run out.

A charge cycle starts only on a rising edge of the request line. A deeply discharged battery first gets trickle current. The cycle then moves to constant-current bulk charge, and then to over-charge once the battery sense reaches the near-target point. In over-charge the regulation becomes constant-voltage and a timeout counter runs on the slow tick. The phase code shows near-full once the current tapers, but charging goes on until the counter expires. At expiry the block shuts down and releases the request line. Every flag is passed through a two-stage synchroniser before use.

Top module: `li_charge_sequencer`

## Requirements
- R1: A charge cycle starts only when the synchronised request goes from low to high while the block is idle. A request that is already high when reset ends, or when lockout ends, starts nothing. Request edges during an active cycle are ignored.
- R2: stateCode is 2'b00 for trickle, 2'b01 for bulk, 2'b10 for over-charge and 2'b11 for top-off. While idle or shut down, stateCode is 2'b00 and driveEn is 0. driveEn is 1 in every charging phase. After reset the block is idle.
- R3: At start the block enters trickle if the low-battery flag is high, and bulk otherwise. From trickle it moves to bulk once the low-battery flag is low.
- R4: From bulk it moves to over-charge when the near-target flag is high. Over-charge and top-off are kept when the near-target flag falls again.
- R5: From over-charge it moves to top-off when the taper flag is high, and it stays in top-off (still charging) when the flag falls. The taper flag has no effect in bulk.
- R6: timerOscEn and voltageMode are 1 exactly in over-charge and top-off, and 0 in trickle, bulk and idle.
- R7: The timeout expires on the 2^TIMER_BITS-th tick seen while in over-charge or top-off. Ticks in other phases are not counted, and the count restarts from zero in every new cycle and after lockout.
- R8: On expiry the block returns to idle in the same clock as the last tick and raises chgRelease. chgRelease stays high until the synchronised request is seen low. Another rising edge is then needed to restart.
- R9: While the synchronised lockout input is high, the block is held idle with driveEn 0, chgRelease 0 and the counter cleared, and request edges are ignored.
- R10: A flag or request change applied before rising clock edge k shows at the outputs after edge k+2 (two synchroniser stages plus the phase register). A tick is acted on at the edge where it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uvloIn | input | 1 | Supply undervoltage lockout flag (asynchronous) |
| chgReqIn | input | 1 | Charge request line (asynchronous) |
| lowBattIn | input | 1 | Battery below trickle threshold (asynchronous) |
| nearTargetIn | input | 1 | Battery sense at 95% of target (asynchronous) |
| taperIn | input | 1 | Charge current below programmed minimum (asynchronous) |
| timerTick | input | 1 | Single-cycle slow timer pulse, synchronous to clk |
| stateCode | output | 2 | Charge phase code |
| timerOscEn | output | 1 | Enable for the slow timer oscillator |
| voltageMode | output | 1 | 1 = constant-voltage regulation, 0 = constant-current |
| driveEn | output | 1 | Output stage enable |
| chgRelease | output | 1 | Pulls the charge request line low after timeout |

## Verification
A wrong phase register shows at once on stateCode, driveEn, timerOscEn or voltageMode, one clock after the bad transition. A timeout counter that miscounts, or that keeps ticks left over from an earlier cycle, shows nothing until expiry, up to 16384 ticks later. So the bench delivers an exact number of ticks in over-charge and checks that the block is still charging one tick before expiry and is idle one tick later. Release handling shows only on chgRelease and on whether the next request edge restarts a cycle. A behavioural model compares all outputs on every clock, so any difference shows within the cycle it appears.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TRICKLE,
    PH_BULK,
    PH_OVER,
    PH_TOPOFF
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } ctrl_strobe_t;

  localparam logic [1:0] CODE_TRICKLE = 2'b00;
  localparam logic [1:0] CODE_BULK    = 2'b01;
  localparam logic [1:0] CODE_OVER    = 2'b10;
  localparam logic [1:0] CODE_TOPOFF  = 2'b11;

  // positions inside the synchronised flag vector
  localparam int FLAG_REQ   = 0;
  localparam int FLAG_TAPER = 1;
  localparam int FLAG_NEAR  = 2;
  localparam int FLAG_LOW   = 3;
  localparam int FLAG_UVLO  = 4;
  localparam int FLAG_COUNT = 5;

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign syncOut = stg[STAGES-1];

endmodule

// File: rtl/chg_timer.sv
module chg_timer import chg_seq_pkg::*; #(
  parameter int TIMER_BITS = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobes,
  input  logic         reqSync,
  output logic         reqRise,
  output logic         expired
);

  localparam logic [TIMER_BITS-1:0] CNT_LAST = {TIMER_BITS{1'b1}};

  logic [TIMER_BITS-1:0] cnt;
  logic                  reqPrev;

  // previous request resets high: a line high out of reset is no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPrev <= 1'b1;
    else       reqPrev <= reqSync;
  end

  assign reqRise = reqSync && !reqPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobes.cntClear) cnt <= '0;
    else if (strobes.cntStep)  cnt <= cnt + 1'b1;
  end

  assign expired = strobes.cntStep && (cnt == CNT_LAST);

  // R7: a cleared counter reads zero next cycle
  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntClear |=> (cnt == '0));

  // R7: expiry wraps the count back to zero
  assert_expire_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (expired && !strobes.cntClear) |=> (cnt == '0));

endmodule

// File: rtl/chg_ctrl.sv
module chg_ctrl import chg_seq_pkg::*; (
  input  logic         clk,
  input  logic         rstN,
  input  logic         uvloS,
  input  logic         lowS,
  input  logic         nearS,
  input  logic         taperS,
  input  logic         reqS,
  input  logic         reqRise,
  input  logic         expired,
  input  logic         timerTick,
  output ctrl_strobe_t strobes,
  output phase_t       phase,
  output logic         releaseHold
);

  phase_t phaseNext;
  logic   timing;

  assign timing = (phase == PH_OVER) || (phase == PH_TOPOFF);

  always_comb begin
    strobes.cntClear = !timing || uvloS;
    strobes.cntStep  = timing && !uvloS && timerTick;
  end

  always_comb begin
    phaseNext = phase;
    if (uvloS || expired) begin
      phaseNext = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:    if (reqRise) phaseNext = lowS ? PH_TRICKLE : PH_BULK;
        PH_TRICKLE: if (!lowS)   phaseNext = PH_BULK;
        PH_BULK:    if (nearS)   phaseNext = PH_OVER;
        PH_OVER:    if (taperS)  phaseNext = PH_TOPOFF;
        PH_TOPOFF:  phaseNext = PH_TOPOFF;
        default:    phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        releaseHold <= 1'b0;
    else if (uvloS)   releaseHold <= 1'b0;
    else if (expired) releaseHold <= 1'b1;
    else if (!reqS)   releaseHold <= 1'b0;
  end

  // R1: idle is left only on a request edge
  assert_start_on_edge_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !reqRise) |=> (phase == PH_IDLE));

  // R5: top-off is sticky until timeout or lockout
  assert_topoff_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TOPOFF && !uvloS && !expired) |=> (phase == PH_TOPOFF));

  // R8: expiry shuts down and releases the request line
  assert_timeout_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (expired && !uvloS) |=> (phase == PH_IDLE && releaseHold));

  // R9: lockout holds idle with release dropped
  assert_uvlo_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    uvloS |=> (phase == PH_IDLE && !releaseHold));

  // R3: trickle is only entered from idle
  assert_trickle_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && phase != PH_TRICKLE) |=> (phase != PH_TRICKLE));

endmodule

// File: rtl/li_charge_sequencer.sv
module li_charge_sequencer import chg_seq_pkg::*; #(
  parameter int TIMER_BITS  = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvloIn,
  input  logic       chgReqIn,
  input  logic       lowBattIn,
  input  logic       nearTargetIn,
  input  logic       taperIn,
  input  logic       timerTick,
  output logic [1:0] stateCode,
  output logic       timerOscEn,
  output logic       voltageMode,
  output logic       driveEn,
  output logic       chgRelease
);

  localparam logic [FLAG_COUNT-1:0] SYNC_RST = FLAG_COUNT'(1) << FLAG_REQ;

  logic [FLAG_COUNT-1:0] flagRaw, flagSync;
  ctrl_strobe_t          strobes;
  phase_t                phase;
  logic                  reqRise, expired, releaseHold;

  always_comb begin
    flagRaw             = '0;
    flagRaw[FLAG_REQ]   = chgReqIn;
    flagRaw[FLAG_TAPER] = taperIn;
    flagRaw[FLAG_NEAR]  = nearTargetIn;
    flagRaw[FLAG_LOW]   = lowBattIn;
    flagRaw[FLAG_UVLO]  = uvloIn;
  end

  chg_sync #(.WIDTH(FLAG_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(flagRaw), .syncOut(flagSync)
  );

  chg_timer #(.TIMER_BITS(TIMER_BITS)) uTimer (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqSync(flagSync[FLAG_REQ]),
    .reqRise(reqRise), .expired(expired)
  );

  chg_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .uvloS(flagSync[FLAG_UVLO]), .lowS(flagSync[FLAG_LOW]),
    .nearS(flagSync[FLAG_NEAR]), .taperS(flagSync[FLAG_TAPER]),
    .reqS(flagSync[FLAG_REQ]), .reqRise(reqRise), .expired(expired),
    .timerTick(timerTick), .strobes(strobes), .phase(phase),
    .releaseHold(releaseHold)
  );

  always_comb begin
    case (phase)
      PH_BULK:   stateCode = CODE_BULK;
      PH_OVER:   stateCode = CODE_OVER;
      PH_TOPOFF: stateCode = CODE_TOPOFF;
      default:   stateCode = CODE_TRICKLE;
    endcase
  end

  assign timerOscEn  = (phase == PH_OVER) || (phase == PH_TOPOFF);
  assign voltageMode = timerOscEn;
  assign driveEn     = (phase != PH_IDLE);
  assign chgRelease  = releaseHold;

endmodule

// File: tb/li_charge_sequencer_test.sv
module li_charge_sequencer_test;

  localparam int TB_BITS = 14;
  localparam int LIMIT   = 1 << TB_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvloIn = 0, chgReqIn = 1, lowBattIn = 0, nearTargetIn = 0, taperIn = 0, timerTick = 0;
  logic [1:0] stateCode;
  logic timerOscEn, voltageMode, driveEn, chgRelease;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  li_charge_sequencer #(.TIMER_BITS(TB_BITS), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .uvloIn(uvloIn), .chgReqIn(chgReqIn),
    .lowBattIn(lowBattIn), .nearTargetIn(nearTargetIn), .taperIn(taperIn),
    .timerTick(timerTick), .stateCode(stateCode), .timerOscEn(timerOscEn),
    .voltageMode(voltageMode), .driveEn(driveEn), .chgRelease(chgRelease)
  );

  // behavioural reference: 0 idle, 1 trickle, 2 bulk, 3 over, 4 top-off
  int mPh, mCnt;
  bit mRel, mPrev;
  bit q1U, q2U, q1L, q2L, q1N, q2N, q1T, q2T, q1R, q2R;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mRel = 0; mPrev = 1;
      q1U = 0; q2U = 0; q1L = 0; q2L = 0; q1N = 0; q2N = 0;
      q1T = 0; q2T = 0; q1R = 1; q2R = 1;
    end else begin
      bit rise, timing, step, expire;
      rise   = q2R && !mPrev;
      timing = (mPh >= 3);
      step   = timing && !q2U && timerTick;
      expire = step && (mCnt == LIMIT - 1);
      if (q2U) mRel = 0;
      else if (expire) mRel = 1;
      else if (!q2R) mRel = 0;
      if (!timing || q2U) mCnt = 0;
      else if (step) mCnt = (mCnt + 1) % LIMIT;
      if (q2U || expire) mPh = 0;
      else begin
        case (mPh)
          0: if (rise) mPh = q2L ? 1 : 2;
          1: if (!q2L) mPh = 2;
          2: if (q2N) mPh = 3;
          3: if (q2T) mPh = 4;
          default: ;
        endcase
      end
      mPrev = q2R;
      q2U = q1U; q1U = uvloIn;
      q2L = q1L; q1L = lowBattIn;
      q2N = q1N; q1N = nearTargetIn;
      q2T = q1T; q1T = taperIn;
      q2R = q1R; q1R = chgReqIn;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      int eCode;
      eCode = (mPh == 2) ? 1 : (mPh == 3) ? 2 : (mPh == 4) ? 3 : 0;
      chk("R2 model stateCode", stateCode, eCode);
      chk("R6 model timerOscEn", timerOscEn, int'(mPh >= 3));
      chk("R6 model voltageMode", voltageMode, int'(mPh >= 3));
      chk("R9 model driveEn", driveEn, int'(mPh != 0));
      chk("R8 model chgRelease", chgRelease, int'(mRel));
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tickPulses(input int n);
    for (int i = 0; i < n; i++) begin
      timerTick = 1'b1;
      @(negedge clk);
      timerTick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 reset code", stateCode, 0);
    chk("R2 reset driveEn", driveEn, 0);
    waitCyc(10);
    chk("R1 high level out of reset no start", driveEn, 0);

    // start with a low battery; check latency
    chgReqIn = 0; waitCyc(4);
    lowBattIn = 1; chgReqIn = 1;
    waitCyc(2);
    chk("R10 not started after two edges", driveEn, 0);
    waitCyc(1);
    chk("R10 started after third edge", driveEn, 1);
    chk("R3 trickle code", stateCode, 0);
    tickPulses(20);
    lowBattIn = 0; waitCyc(4);
    chk("R3 bulk after low clears", stateCode, 1);
    chk("R6 current mode in bulk", voltageMode, 0);
    chgReqIn = 0; waitCyc(4); chgReqIn = 1; waitCyc(4);
    chk("R1 edge ignored mid-charge", stateCode, 1);
    taperIn = 1; waitCyc(4);
    chk("R5 taper ignored in bulk", stateCode, 1);
    taperIn = 0; tickPulses(20);
    nearTargetIn = 1; waitCyc(4);
    chk("R4 over-charge entered", stateCode, 2);
    chk("R6 oscillator on in over-charge", timerOscEn, 1);
    chk("R6 voltage mode in over-charge", voltageMode, 1);
    nearTargetIn = 0; waitCyc(4);
    chk("R4 over-charge kept when near falls", stateCode, 2);
    taperIn = 1; waitCyc(4);
    chk("R5 top-off code", stateCode, 3);
    taperIn = 0; waitCyc(4);
    chk("R5 top-off sticky", stateCode, 3);
    chk("R5 still charging in top-off", driveEn, 1);

    tickPulses(LIMIT - 1); waitCyc(2);
    chk("R7 still charging one tick before expiry", stateCode, 3);
    timerTick = 1; @(negedge clk); timerTick = 0;
    chk("R8 idle at expiry", driveEn, 0);
    chk("R8 release raised", chgRelease, 1);
    waitCyc(10);
    chk("R8 release held while request high", chgRelease, 1);
    chk("R8 no restart while held", driveEn, 0);
    chgReqIn = 0; waitCyc(4);
    chk("R8 release dropped after request low", chgRelease, 0);

    // second cycle: battery above threshold, then lockout
    chgReqIn = 1; waitCyc(4);
    chk("R3 trickle skipped", stateCode, 1);
    nearTargetIn = 1; waitCyc(4);
    chk("R4 over-charge second cycle", stateCode, 2);
    tickPulses(100);
    uvloIn = 1; waitCyc(4);
    chk("R9 lockout stops drive", driveEn, 0);
    chk("R9 lockout stops oscillator", timerOscEn, 0);
    chgReqIn = 0; waitCyc(4); chgReqIn = 1; waitCyc(4);
    chk("R9 edge ignored under lockout", driveEn, 0);
    uvloIn = 0; waitCyc(6);
    chk("R1 high level after lockout no start", driveEn, 0);
    chgReqIn = 0; waitCyc(4); chgReqIn = 1; waitCyc(5);
    chk("R4 over-charge third cycle", stateCode, 2);
    tickPulses(LIMIT - 1); waitCyc(2);
    chk("R7 counter restarted, no carry-over", stateCode, 2);
    timerTick = 1; @(negedge clk); timerTick = 0;
    chk("R7 expiry on exact tick count", driveEn, 0);
    chk("R8 release after second timeout", chgRelease, 1);
    chgReqIn = 0; waitCyc(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule